// File: doc/BRIEF.md
# Link-Side Packet Receive Decoder

This block sits on the link side of a PHY-to-link interface. On every clock edge it samples a 2-bit control bus and an 8-bit data bus. It follows the receive sequence and works out the packet speed from an in-band code. It then streams the packet bytes to downstream logic, with start-of-packet and end-of-packet markers and the decoded speed on every byte.

A receive opens with one or more all-ones bytes. A single speed-code byte follows, and then the packet bytes, until the control bus leaves Receive. The decoder rejects a packet when the speed code is unknown or faster than the configured link capability. In that case it raises a one-cycle drop pulse and delivers none of the packet's bytes. A receive that ends before any byte is delivered raises a one-cycle null pulse instead. The speed code is never forwarded as data, so downstream CRC logic never sees it.

The end of a packet is only known when the control bus returns to a non-Receive code. For this reason each byte is held for one cycle, so that the end marker can sit on the last byte.

Top module: `rx_pkt_decoder`

## Requirements
- R1: While reset is low, and on the first output cycle after it rises, dout_valid, dout_sop, dout_eop, drop_pulse, null_pulse and err_pulse are all 0.
- R2: The control bus codes are 00 Idle, 01 Status, 10 Receive and 11 invalid. A receive starts on any cycle showing 10, including a cycle that directly follows a Status cycle with no Idle between.
- R3: At the start of a receive, any number (one or more) of 0xFF bytes is skipped. The first non-0xFF byte is the speed code, and it never appears on dout.
- R4: Speed code 0x00 gives dout_speed 0, 0x40 gives 1, and 0x50 gives 2. Every delivered byte carries the speed of its packet, and dout_speed is never 3 while dout_valid is high.
- R5: If the decoded speed is not above link_cap, every Receive byte after the speed code is delivered in order, unchanged, including bytes equal to 0xFF.
- R6: dout_sop marks the first delivered byte of a packet and dout_eop marks the last. A one-byte packet has both markers on the same byte. The last byte is emitted on the cycle after the control bus leaves Receive.
- R7: A speed code that is not 0x00, 0x40 or 0x50, or a valid speed above link_cap, gives exactly one drop_pulse cycle, and no byte of that receive is delivered.
- R8: A receive that ends with Idle or Status and has delivered no byte, and was not dropped, gives exactly one null_pulse cycle. This covers a run of 0xFF bytes alone, and a speed code with no packet bytes.
- R9: Control code 11 during a receive ends it with exactly one err_pulse cycle. Any byte still held is emitted with dout_eop, and no null_pulse is raised.
- R10: dout_valid is low after two consecutive non-Receive cycles. dout_valid, drop_pulse and null_pulse are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl | input | 2 | Control bus from the PHY (00 Idle, 01 Status, 10 Receive, 11 invalid) |
| din | input | 8 | Data bus from the PHY |
| link_cap | input | 2 | Highest speed the link accepts (0, 1, 2; 3 accepts all) |
| dout | output | 8 | Packet byte |
| dout_valid | output | 1 | dout holds a packet byte |
| dout_sop | output | 1 | First byte of a packet |
| dout_eop | output | 1 | Last byte of a packet |
| dout_speed | output | 2 | Speed of the packet the byte belongs to |
| drop_pulse | output | 1 | One cycle: packet rejected for its speed |
| null_pulse | output | 1 | One cycle: receive ended with no data |
| err_pulse | output | 1 | One cycle: receive aborted by control code 11 |

## Verification
Every speed code is swept against every link capability, with one and two prefix bytes and payloads of zero, one and three bytes. The three valid codes compared with the capability separate accepted packets from drops. The five invalid codes show that only exact matches are decoded. Zero-byte payloads separate the null case from the drop case. A payload that contains 0xFF shows that data is not mistaken for prefix. Runs that lead in from Status, and runs that end on code 11 from prefix, data and drop states, confirm that a receive starts straight out of Status and that aborts are flagged without a null.

// File: rtl/rx_pkt_decoder.sv
module rx_pkt_decoder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ctl,
  input  logic [DW-1:0] din,
  input  logic [1:0]    link_cap,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic          dout_sop,
  output logic          dout_eop,
  output logic [1:0]    dout_speed,
  output logic          drop_pulse,
  output logic          null_pulse,
  output logic          err_pulse
);

  localparam logic [1:0]    CTL_RX  = 2'b10;
  localparam logic [1:0]    CTL_BAD = 2'b11;
  localparam logic [DW-1:0] DATA_ON = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_SKIP} st_t;

  st_t           st;
  logic [DW-1:0] hold_data;
  logic          hold_vld, hold_first, byte_seen;
  logic [1:0]    speed_q;

  wire is_rx  = (ctl == CTL_RX);
  wire is_bad = (ctl == CTL_BAD);
  wire is_on  = (din == DATA_ON);

  logic       code_ok;
  logic [1:0] code_idx;
  always_comb begin
    code_ok  = 1'b1;
    code_idx = 2'd0;
    case (din)
      8'h00:   code_idx = 2'd0;
      8'h40:   code_idx = 2'd1;
      8'h50:   code_idx = 2'd2;
      default: code_ok  = 1'b0;
    endcase
  end
  wire accept = code_ok && (code_idx <= link_cap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      hold_data  <= '0;
      hold_vld   <= 1'b0;
      hold_first <= 1'b0;
      byte_seen  <= 1'b0;
      speed_q    <= 2'd0;
      dout       <= '0;
      dout_valid <= 1'b0;
      dout_sop   <= 1'b0;
      dout_eop   <= 1'b0;
      dout_speed <= 2'd0;
      drop_pulse <= 1'b0;
      null_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      dout_sop   <= 1'b0;
      dout_eop   <= 1'b0;
      drop_pulse <= 1'b0;
      null_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      case (st)
        ST_IDLE, ST_PRE: begin
          if (is_rx) begin
            if (is_on) begin
              st <= ST_PRE;
            end else if (accept) begin
              st        <= ST_DATA;
              speed_q   <= code_idx;
              byte_seen <= 1'b0;
            end else begin
              st         <= ST_SKIP;
              drop_pulse <= 1'b1;
            end
          end else if (st == ST_PRE) begin
            st         <= ST_IDLE;
            err_pulse  <= is_bad;
            null_pulse <= !is_bad;
          end
        end
        ST_DATA: begin
          if (is_rx) begin
            if (hold_vld) begin
              dout       <= hold_data;
              dout_valid <= 1'b1;
              dout_sop   <= hold_first;
              dout_speed <= speed_q;
            end
            hold_data  <= din;
            hold_vld   <= 1'b1;
            hold_first <= !byte_seen;
            byte_seen  <= 1'b1;
          end else begin
            st        <= ST_IDLE;
            err_pulse <= is_bad;
            if (hold_vld) begin
              dout       <= hold_data;
              dout_valid <= 1'b1;
              dout_sop   <= hold_first;
              dout_eop   <= 1'b1;
              dout_speed <= speed_q;
              hold_vld   <= 1'b0;
            end else begin
              null_pulse <= !is_bad;
            end
          end
        end
        ST_SKIP: begin
          if (!is_rx) begin
            st        <= ST_IDLE;
            err_pulse <= is_bad;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  speed_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> dout_speed != 2'd3);

  // R5
  speed_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> dout_speed <= link_cap);

  // R6
  sop_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_sop || dout_eop) |-> dout_valid);

  // R7
  drop_after_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_pulse) |-> $past(ctl) == CTL_RX);

  // R8
  null_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    null_pulse |-> $past(ctl) != CTL_RX && $past(ctl) != CTL_BAD);

  // R10
  quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl != CTL_RX) ##1 (ctl != CTL_RX) |=> !dout_valid);

  // R10
  exclusive_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dout_valid, drop_pulse, null_pulse}));

endmodule

// File: tb/rx_pkt_decoder_bench.sv
`timescale 1ns/1ps
module rx_pkt_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic [7:0] din = 8'h00;
  logic [1:0] link_cap = 2'd3;
  logic [7:0] dout;
  logic       dout_valid, dout_sop, dout_eop, drop_pulse, null_pulse, err_pulse;
  logic [1:0] dout_speed;

  always #2 clk = ~clk;

  rx_pkt_decoder u_rx_pkt_decoder (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .din(din), .link_cap(link_cap),
    .dout(dout), .dout_valid(dout_valid), .dout_sop(dout_sop), .dout_eop(dout_eop),
    .dout_speed(dout_speed), .drop_pulse(drop_pulse), .null_pulse(null_pulse),
    .err_pulse(err_pulse)
  );

  int vectors = 0;
  int fails = 0;

  logic [7:0] m_data [0:63];
  logic       m_sop  [0:63];
  logic       m_eop  [0:63];
  logic [1:0] m_spd  [0:63];
  int m_n = 0, m_drop = 0, m_null = 0, m_err = 0;

  always @(negedge clk) if (rst_n) begin
    if (dout_valid && m_n < 64) begin
      m_data[m_n] = dout; m_sop[m_n] = dout_sop;
      m_eop[m_n] = dout_eop; m_spd[m_n] = dout_speed;
      m_n = m_n + 1;
    end
    if (drop_pulse) m_drop = m_drop + 1;
    if (null_pulse) m_null = m_null + 1;
    if (err_pulse)  m_err  = m_err + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] c, input logic [7:0] d);
    ctl = c; din = d;
    @(posedge clk); #1;
  endtask

  task automatic run_pkt(input int pre, input bit has_spd, input logic [7:0] code,
                         input int nb, input logic [1:0] cap, input bit lead_status,
                         input bit abort, input logic [7:0] seed);
    bit ok_code, accepted, dropped;
    int idx, exp_n;
    link_cap = cap;
    m_n = 0; m_drop = 0; m_null = 0; m_err = 0;
    if (lead_status) for (int i = 0; i < 3; i++) cyc(2'b01, seed ^ 8'h5A);
    for (int i = 0; i < pre; i++) cyc(2'b10, 8'hFF);
    if (has_spd) cyc(2'b10, code);
    for (int i = 0; i < nb; i++) cyc(2'b10, seed + 8'(i));
    if (abort) cyc(2'b11, 8'h00);
    for (int i = 0; i < 3; i++) cyc(2'b00, 8'h00);

    ok_code = (code == 8'h00) || (code == 8'h40) || (code == 8'h50);
    idx = (code == 8'h40) ? 1 : (code == 8'h50) ? 2 : 0;
    accepted = has_spd && ok_code && (idx <= int'(cap));
    dropped  = has_spd && !accepted;
    exp_n    = accepted ? nb : 0;

    check(m_n == exp_n, dropped ? "R7 byte count" : "R5 byte count", m_n, exp_n);
    check(m_drop == (dropped ? 1 : 0), "R7 drop pulses", m_drop, dropped ? 1 : 0);
    check(m_null == ((!abort && !dropped && exp_n == 0) ? 1 : 0), "R8 null pulses",
          m_null, (!abort && !dropped && exp_n == 0) ? 1 : 0);
    check(m_err == (abort ? 1 : 0), "R9 err pulses", m_err, abort ? 1 : 0);
    if (m_n == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        check(m_data[i] == seed + 8'(i), "R3/R5 data byte", m_data[i], seed + 8'(i));
        check(m_spd[i] == 2'(idx), "R4 speed", m_spd[i], idx);
        check(m_sop[i] == (i == 0), "R6 sop", m_sop[i], i == 0);
        check(m_eop[i] == (i == exp_n - 1), "R6 eop", m_eop[i], i == exp_n - 1);
      end
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] codes [0:7];
    codes[0] = 8'h00; codes[1] = 8'h40; codes[2] = 8'h50; codes[3] = 8'h01;
    codes[4] = 8'h41; codes[5] = 8'h51; codes[6] = 8'h80; codes[7] = 8'hFE;
    ctl = 2'b10; din = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check({dout_valid, dout_sop, dout_eop, drop_pulse, null_pulse, err_pulse} == 6'b0,
          "R1 reset outputs", {dout_valid, dout_sop, dout_eop, drop_pulse, null_pulse, err_pulse}, 0);
    ctl = 2'b00; din = 8'h00;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check({dout_valid, drop_pulse, null_pulse, err_pulse} == 4'b0,
          "R1 first cycle after reset", {dout_valid, drop_pulse, null_pulse, err_pulse}, 0);

    for (int c = 0; c < 8; c++)
      for (int cap = 0; cap < 4; cap++)
        for (int pre = 1; pre <= 2; pre++) begin
          run_pkt(pre, 1'b1, codes[c], 0, 2'(cap), 1'b0, 1'b0, 8'h10);
          run_pkt(pre, 1'b1, codes[c], 1, 2'(cap), 1'b0, 1'b0, 8'hA3);
          run_pkt(pre, 1'b1, codes[c], 3, 2'(cap), 1'b0, 1'b0, 8'hFE);
        end

    for (int pre = 1; pre <= 4; pre++)
      run_pkt(pre, 1'b0, 8'h00, 0, 2'd2, 1'b0, 1'b0, 8'h00);

    // R2: receive straight out of status
    run_pkt(1, 1'b1, 8'h40, 4, 2'd2, 1'b1, 1'b0, 8'h21);
    run_pkt(3, 1'b1, 8'h50, 2, 2'd3, 1'b1, 1'b0, 8'hFD);
    run_pkt(2, 1'b0, 8'h00, 0, 2'd1, 1'b1, 1'b0, 8'h00);

    // R9: aborts from prefix, data and drop states
    run_pkt(2, 1'b0, 8'h00, 0, 2'd2, 1'b0, 1'b1, 8'h00);
    run_pkt(1, 1'b1, 8'h00, 3, 2'd2, 1'b0, 1'b1, 8'h30);
    run_pkt(1, 1'b1, 8'h00, 1, 2'd0, 1'b0, 1'b1, 8'h44);
    run_pkt(1, 1'b1, 8'h50, 2, 2'd1, 1'b0, 1'b1, 8'h60);
    run_pkt(1, 1'b1, 8'h00, 0, 2'd2, 1'b0, 1'b1, 8'h00);

    // R6: last byte timing for a one-byte packet
    link_cap = 2'd2;
    cyc(2'b10, 8'hFF); cyc(2'b10, 8'h00); cyc(2'b10, 8'h77);
    check(dout_valid == 1'b0, "R6 byte held while receive continues", dout_valid, 0);
    cyc(2'b00, 8'h00);
    check(dout_valid && dout_sop && dout_eop && dout == 8'h77, "R6 last byte on cycle after end",
          {dout_valid, dout_sop, dout_eop}, 7);
    cyc(2'b00, 8'h00);
    check(dout_valid == 1'b0, "R10 quiet after idle", dout_valid, 0);
    repeat (2) cyc(2'b00, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule